// File: doc/BRIEF.md
# Framed Coefficient and Control Loader

This block sits behind a synchronous serial port whose shift logic has already assembled each frame into four parallel 16-bit slots. It takes one frame per `frame_valid_i` pulse. Slot 0 is a control word. Its register field can write one of four 8-bit control registers. Its mode, start and RAM-select bits steer the three data slots into one of three coefficient RAMs, or pass them on as signal samples.

A coefficient load opens with a start frame. The start frame carries only two words: slot 1 is skipped. Each later frame aimed at the same RAM adds three words, until 38 words have been written. The words of a frame are sent to a single RAM write port one per cycle, in the three cycles after the frame is taken. Frames must therefore be at least three cycles apart. A register write and coefficient writes in the same frame do not interfere with each other.

Top module: `coef_frame_loader`

## Requirements
- R1: A frame is taken on a clock edge where `frame_valid_i` is high, and frames are at least three cycles apart. The slot 0 fields are: bit 15 mode (1 = coefficient load, 0 = data), bit 14 start, bits 12:11 RAM select, bits 10:8 register address, bits 7:0 register data.
- R2: A register address of 0 to 3 stores the data byte in that register, which appears on `ctrl_regs_o[8*a +: 8]`. Bit a of `ctrl_we_o` is high for the one cycle after the frame edge. Addresses 4 to 7 change no register and raise no strobe.
- R3: A register write takes place in both modes, and whether or not the same frame also loads coefficients.
- R4: A start frame (bit 15 = 1, bit 14 = 1, RAM select 00, 01 or 10) restarts the load of that RAM. It clears `load_done_o`, skips slot 1, and writes slot 2 to address 0 and slot 3 to address 1.
- R5: A continuation frame (bit 15 = 1, bit 14 = 0, same RAM select as the last start) writes slots 1, 2 and 3 to the next three addresses. The writes are on `ram_we_o` in the three cycles after the frame edge, one per cycle, with `ram_sel_o` equal to the RAM select.
- R6: No coefficient is written by a continuation frame that names another RAM, by any frame with RAM select 11, or by a continuation frame that arrives before any start frame. Such frames leave the progress of a load unchanged.
- R7: At most 38 words (addresses 0 to 37) are written per load, and any further words are dropped. `load_done_o` rises the cycle after the write to address 37 and stays high until the next start frame or reset.
- R8: A data-mode frame (bit 15 = 0) writes no coefficient. In the cycle after the frame edge it raises `sample_valid_o` for one cycle, with `tx_sample_o` = slot 1 and `res_sample_o` = slot 2.
- R9: Reset clears the loader state, all write strobes, `load_done_o`, the sample outputs and all control registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_valid_i | input | 1 | Frame present on the slot inputs |
| slot0_i | input | 16 | Control word |
| slot1_i | input | 16 | Data slot 1 |
| slot2_i | input | 16 | Data slot 2 |
| slot3_i | input | 16 | Data slot 3 |
| ctrl_we_o | output | 4 | Per-register write strobes |
| ctrl_regs_o | output | 32 | Control registers, register a in bits 8a+7:8a |
| ram_we_o | output | 1 | Coefficient RAM write enable |
| ram_sel_o | output | 2 | Target RAM (00, 01, 10) |
| ram_addr_o | output | 6 | Coefficient word address |
| ram_data_o | output | 16 | Coefficient word |
| load_done_o | output | 1 | All 38 words of the current load written |
| sample_valid_o | output | 1 | New data-mode samples |
| tx_sample_o | output | 16 | Transmit sample from slot 1 |
| res_sample_o | output | 16 | Residual sample from slot 2 |

## Verification
The hardest case to reach is the 38-word boundary. Getting there takes a start frame followed by twelve accepted continuation frames. During that load the stimulus also sends frames naming another RAM, frames with RAM select 11, and data-mode frames, all of which must leave the address progress untouched. After the last accepted word, one more continuation frame must write nothing. A second load on a new RAM then checks that done clears, and a third start in the middle of that load checks that addresses restart at zero.

// File: rtl/cfl_pkg.sv
package cfl_pkg;

  typedef struct packed {
    logic       coef_mode;
    logic       start;
    logic       clk_sel;
    logic [1:0] ram_sel;
    logic [2:0] reg_addr;
    logic [7:0] reg_data;
  } ctrl_word_t;

  localparam logic [1:0] RAM_NONE = 2'b11;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_START = 2'd1,
    ACT_CONT  = 2'd2
  } coef_act_e;

endpackage

// File: rtl/cfl_frame_decode.sv
module cfl_frame_decode
  import cfl_pkg::*;
#(
  parameter int N_REGS = 4
) (
  input  logic       frame_valid_i,
  input  ctrl_word_t ctrl_i,
  input  logic       load_active_i,
  input  logic [1:0] load_sel_i,
  output coef_act_e  act_o,
  output logic       reg_wr_o,
  output logic       sample_wr_o
);

  always_comb begin
    act_o = ACT_NONE;
    if (frame_valid_i && ctrl_i.coef_mode && (ctrl_i.ram_sel != RAM_NONE)) begin
      if (ctrl_i.start) act_o = ACT_START;
      else if (load_active_i && (ctrl_i.ram_sel == load_sel_i)) act_o = ACT_CONT;
    end
  end

  assign reg_wr_o    = frame_valid_i && (int'(ctrl_i.reg_addr) < N_REGS);
  assign sample_wr_o = frame_valid_i && !ctrl_i.coef_mode;

endmodule

// File: rtl/cfl_reg_file.sv
module cfl_reg_file #(
  parameter int N_REGS = 4,
  parameter int REG_W  = 8,
  parameter int IDX_W  = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [REG_W-1:0]        data_i,
  output logic [N_REGS-1:0]       we_o,
  output logic [N_REGS*REG_W-1:0] regs_o
);

  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    logic [REG_W-1:0] r_q;
    logic             w_q;
    logic             hit;

    assign hit = wr_i && (idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        r_q <= '0;
        w_q <= 1'b0;
      end else begin
        w_q <= hit;
        if (hit) r_q <= data_i;
      end
    end

    assign we_o[g]                  = w_q;
    assign regs_o[g*REG_W +: REG_W] = r_q;
  end

  // R2
  ctrl_we_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we_o));

endmodule

// File: rtl/cfl_coef_loader.sv
module cfl_coef_loader
  import cfl_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int DATA_SLOTS = 3,
  parameter int RAM_WORDS  = 38,
  parameter int ADDR_W     = $clog2(RAM_WORDS + 1)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  coef_act_e                         act_i,
  input  logic [1:0]                        sel_i,
  input  logic [DATA_SLOTS-1:0][WORD_W-1:0] data_i,
  output logic                              active_o,
  output logic [1:0]                        active_sel_o,
  output logic                              ram_we_o,
  output logic [1:0]                        ram_sel_o,
  output logic [ADDR_W-1:0]                 ram_addr_o,
  output logic [WORD_W-1:0]                 ram_data_o,
  output logic                              done_o
);

  localparam int PW = $clog2(DATA_SLOTS + 1);
  localparam int HW = (DATA_SLOTS > 1) ? $clog2(DATA_SLOTS) : 1;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(RAM_WORDS - 1);

  logic                              active_q;
  logic [1:0]                        sel_q;
  logic [ADDR_W-1:0]                 fill_q;
  logic [ADDR_W-1:0]                 wr_addr_q;
  logic                              done_q, done_d;
  logic [DATA_SLOTS-1:0][WORD_W-1:0] buf_q, buf_d;
  logic [PW-1:0]                     pend_q, take_d;
  logic [HW-1:0]                     head_q;
  logic                              capture;
  int                                skip_c, room_c, cand_c;

  assign capture = (act_i != ACT_NONE);

  // start frames drop the first data slot
  always_comb begin
    skip_c = (act_i == ACT_START) ? 1 : 0;
    room_c = (act_i == ACT_START) ? RAM_WORDS : RAM_WORDS - int'(fill_q);
    cand_c = DATA_SLOTS - skip_c;
    if (room_c < cand_c) cand_c = room_c;
    if (cand_c < 0) cand_c = 0;
    take_d = PW'(cand_c);
    for (int i = 0; i < DATA_SLOTS; i++) begin
      buf_d[i] = (i + skip_c < DATA_SLOTS) ? data_i[i + skip_c] : '0;
    end
  end

  // a start frame clears done even when the final write drains on the same edge
  always_comb begin
    done_d = done_q;
    if (act_i == ACT_START) done_d = 1'b0;
    else if ((pend_q != '0) && (wr_addr_q == LAST)) done_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      sel_q     <= '0;
      fill_q    <= '0;
      wr_addr_q <= '0;
      done_q    <= 1'b0;
      buf_q     <= '0;
      pend_q    <= '0;
      head_q    <= '0;
    end else begin
      done_q <= done_d;
      if (capture) begin
        buf_q  <= buf_d;
        pend_q <= take_d;
        head_q <= '0;
        if (act_i == ACT_START) begin
          active_q  <= 1'b1;
          sel_q     <= sel_i;
          fill_q    <= ADDR_W'(take_d);
          wr_addr_q <= '0;
        end else begin
          fill_q    <= fill_q + ADDR_W'(take_d);
          wr_addr_q <= fill_q;
        end
      end else if (pend_q != '0) begin
        pend_q    <= pend_q - PW'(1);
        head_q    <= head_q + HW'(1);
        wr_addr_q <= wr_addr_q + ADDR_W'(1);
      end
    end
  end

  assign active_o     = active_q;
  assign active_sel_o = sel_q;
  assign ram_we_o     = (pend_q != '0);
  assign ram_sel_o    = sel_q;
  assign ram_addr_o   = wr_addr_q;
  assign ram_data_o   = buf_q[head_q];
  assign done_o       = done_q;

  // R1
  frame_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i != ACT_NONE) |-> (pend_q <= PW'(1)));

  // R7
  addr_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_addr_o <= LAST));

  // R7
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(ram_we_o) && ($past(ram_addr_o) == LAST)));

endmodule

// File: rtl/coef_frame_loader.sv
module coef_frame_loader
  import cfl_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int N_REGS    = 4,
  parameter int REG_W     = 8,
  parameter int RAM_WORDS = 38,
  parameter int ADDR_W    = $clog2(RAM_WORDS + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    frame_valid_i,
  input  logic [WORD_W-1:0]       slot0_i,
  input  logic [WORD_W-1:0]       slot1_i,
  input  logic [WORD_W-1:0]       slot2_i,
  input  logic [WORD_W-1:0]       slot3_i,
  output logic [N_REGS-1:0]       ctrl_we_o,
  output logic [N_REGS*REG_W-1:0] ctrl_regs_o,
  output logic                    ram_we_o,
  output logic [1:0]              ram_sel_o,
  output logic [ADDR_W-1:0]       ram_addr_o,
  output logic [WORD_W-1:0]       ram_data_o,
  output logic                    load_done_o,
  output logic                    sample_valid_o,
  output logic [WORD_W-1:0]       tx_sample_o,
  output logic [WORD_W-1:0]       res_sample_o
);

  localparam int DATA_SLOTS = 3;

  ctrl_word_t                        ctrl;
  coef_act_e                         act;
  logic                              reg_wr, sample_wr, load_active;
  logic [1:0]                        load_sel;
  logic [DATA_SLOTS-1:0][WORD_W-1:0] data_slots;

  assign ctrl       = ctrl_word_t'(slot0_i[15:0]);
  assign data_slots = {slot3_i, slot2_i, slot1_i};

  cfl_frame_decode #(.N_REGS(N_REGS)) i_decode (
    .frame_valid_i (frame_valid_i),
    .ctrl_i        (ctrl),
    .load_active_i (load_active),
    .load_sel_i    (load_sel),
    .act_o         (act),
    .reg_wr_o      (reg_wr),
    .sample_wr_o   (sample_wr)
  );

  cfl_reg_file #(.N_REGS(N_REGS), .REG_W(REG_W), .IDX_W(3)) i_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (reg_wr),
    .idx_i  (ctrl.reg_addr),
    .data_i (REG_W'(ctrl.reg_data)),
    .we_o   (ctrl_we_o),
    .regs_o (ctrl_regs_o)
  );

  cfl_coef_loader #(
    .WORD_W(WORD_W), .DATA_SLOTS(DATA_SLOTS), .RAM_WORDS(RAM_WORDS), .ADDR_W(ADDR_W)
  ) i_loader (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .act_i        (act),
    .sel_i        (ctrl.ram_sel),
    .data_i       (data_slots),
    .active_o     (load_active),
    .active_sel_o (load_sel),
    .ram_we_o     (ram_we_o),
    .ram_sel_o    (ram_sel_o),
    .ram_addr_o   (ram_addr_o),
    .ram_data_o   (ram_data_o),
    .done_o       (load_done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_valid_o <= 1'b0;
      tx_sample_o    <= '0;
      res_sample_o   <= '0;
    end else begin
      sample_valid_o <= sample_wr;
      if (sample_wr) begin
        tx_sample_o  <= slot1_i;
        res_sample_o <= slot2_i;
      end
    end
  end

  // R8
  data_mode_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && !slot0_i[15]) |=> !ram_we_o);

  // R8
  sample_from_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |-> $past(frame_valid_i));

endmodule

// File: tb/test_coef_frame_loader.sv
module test_coef_frame_loader;

  typedef struct {
    int          addr;
    logic [15:0] data;
    logic [1:0]  sel;
  } wr_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fv = 1'b0;
  logic [15:0] s0 = '0, s1 = '0, s2 = '0, s3 = '0;

  logic [3:0]  ctrl_we;
  logic [31:0] ctrl_regs;
  logic        ram_we, load_done, sample_valid;
  logic [1:0]  ram_sel;
  logic [5:0]  ram_addr;
  logic [15:0] ram_data, tx_s, res_s;

  int checks = 0, fails = 0, cyc = 0;
  bit cmp_en = 0, finished = 0;
  string cur_req = "R5";

  wr_t         wq[$];
  logic [7:0]  m_regs[4];
  logic [3:0]  m_we;
  bit          m_active, m_done, m_sv;
  logic [1:0]  m_sel;
  int          m_next;
  logic [15:0] m_tx, m_res;

  always #10 clk = ~clk;

  coef_frame_loader i_coef_frame_loader (
    .clk_i(clk), .rst_ni(rst_n), .frame_valid_i(fv),
    .slot0_i(s0), .slot1_i(s1), .slot2_i(s2), .slot3_i(s3),
    .ctrl_we_o(ctrl_we), .ctrl_regs_o(ctrl_regs),
    .ram_we_o(ram_we), .ram_sel_o(ram_sel), .ram_addr_o(ram_addr), .ram_data_o(ram_data),
    .load_done_o(load_done), .sample_valid_o(sample_valid),
    .tx_sample_o(tx_s), .res_sample_o(res_s)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model: state after each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      wq.delete();
      foreach (m_regs[k]) m_regs[k] = '0;
      m_we = '0; m_active = 0; m_done = 0; m_sv = 0; m_sel = '0; m_next = 0;
      m_tx = '0; m_res = '0;
    end else begin
      if (wq.size() > 0) begin
        wr_t e;
        e = wq.pop_front();
        if (e.addr == 37) m_done = 1;
      end
      m_we = '0;
      m_sv = 0;
      if (fv) begin
        logic [15:0] w[3];
        w[0] = s1; w[1] = s2; w[2] = s3;
        if (s0[10:8] < 4) begin
          m_regs[s0[10:8]] = s0[7:0];
          m_we[s0[10:8]] = 1'b1;
        end
        if (!s0[15]) begin
          m_sv = 1; m_tx = s1; m_res = s2;
        end else if (s0[12:11] != 2'b11) begin
          if (s0[14]) begin
            m_active = 1; m_sel = s0[12:11]; m_next = 0; m_done = 0;
            for (int k = 1; k < 3; k++) begin
              wq.push_back('{m_next, w[k], m_sel}); m_next++;
            end
          end else if (m_active && s0[12:11] == m_sel) begin
            for (int k = 0; k < 3; k++) begin
              if (m_next < 38) begin
                wq.push_back('{m_next, w[k], m_sel}); m_next++;
              end
            end
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk(cur_req, {31'd0, ram_we}, {31'd0, wq.size() > 0});
      if (ram_we && wq.size() > 0) begin
        chk(cur_req, {26'd0, ram_addr}, wq[0].addr);
        chk(cur_req, {16'd0, ram_data}, {16'd0, wq[0].data});
        chk(cur_req, {30'd0, ram_sel}, {30'd0, wq[0].sel});
      end
      chk("R7", {31'd0, load_done}, {31'd0, m_done});
      chk("R2", {28'd0, ctrl_we}, {28'd0, m_we});
      for (int k = 0; k < 4; k++) chk("R2", {24'd0, ctrl_regs[k*8 +: 8]}, {24'd0, m_regs[k]});
      chk("R8", {31'd0, sample_valid}, {31'd0, m_sv});
      if (m_sv) begin
        chk("R8", {16'd0, tx_s}, {16'd0, m_tx});
        chk("R8", {16'd0, res_s}, {16'd0, m_res});
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000 && !finished) begin
      checks++; fails++;
      $display("FAIL watchdog all requirements actual=%0d expected=<20000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic send(bit ms, bit stb, logic [1:0] sel, logic [2:0] ra, logic [7:0] rd,
                      logic [15:0] a, logic [15:0] b, logic [15:0] c);
    @(negedge clk);
    fv = 1'b1; s0 = {ms, stb, 1'b0, sel, ra, rd}; s1 = a; s2 = b; s3 = c;
    @(negedge clk);
    fv = 1'b0; s0 = '0; s1 = '0; s2 = '0; s3 = '0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R9", {28'd0, ctrl_we}, 32'd0);
    chk("R9", ctrl_regs, 32'd0);
    chk("R9", {31'd0, ram_we}, 32'd0);
    chk("R9", {31'd0, load_done}, 32'd0);
    chk("R9", {31'd0, sample_valid}, 32'd0);
    rst_n = 1'b1;
    cmp_en = 1;

    // register writes, addresses 4..7 ignored
    cur_req = "R2";
    send(0, 0, 2'b11, 3'd2, 8'hA5, 16'h1111, 16'h2222, 16'h3333);
    chk("R1", {24'd0, ctrl_regs[23:16]}, 32'hA5);
    send(1, 0, 2'b11, 3'd0, 8'h3C, 0, 0, 0);
    send(1, 0, 2'b11, 3'd3, 8'h81, 0, 0, 0);
    send(1, 0, 2'b11, 3'd1, 8'h5A, 0, 0, 0);
    send(1, 0, 2'b11, 3'd5, 8'hFF, 0, 0, 0);
    send(1, 0, 2'b11, 3'd7, 8'hEE, 0, 0, 0);

    // data mode with a register write in the same frame
    cur_req = "R8";
    send(0, 1, 2'b00, 3'd1, 8'h77, 16'hBEEF, 16'hCAFE, 16'hD00D);
    chk("R3", {24'd0, ctrl_regs[15:8]}, 32'h77);

    // nothing loads without a proper start
    cur_req = "R6";
    send(1, 0, 2'b00, 3'd7, 0, 16'h0001, 16'h0002, 16'h0003);
    send(1, 1, 2'b11, 3'd7, 0, 16'h0004, 16'h0005, 16'h0006);

    // full load of RAM select 01 with foreign frames in between
    cur_req = "R4";
    send(1, 1, 2'b01, 3'd3, 8'h42, 16'hDEAD, 16'h2001, 16'h2002);
    chk("R3", {24'd0, ctrl_regs[31:24]}, 32'h42);
    cur_req = "R5";
    for (int f = 1; f <= 12; f++) begin
      send(1, 0, 2'b01, 3'd7, 0, 16'h2000 + 16'(f*16 + 1),
           16'h2000 + 16'(f*16 + 2), 16'h2000 + 16'(f*16 + 3));
      if (f == 4) begin
        cur_req = "R6";
        send(1, 0, 2'b00, 3'd7, 0, 16'h0BAD, 16'h0BAD, 16'h0BAD);
        send(1, 1, 2'b11, 3'd7, 0, 16'h0BAD, 16'h0BAD, 16'h0BAD);
        cur_req = "R8";
        send(0, 0, 2'b01, 3'd7, 0, 16'h4444, 16'h5555, 16'h6666);
        cur_req = "R5";
      end
    end
    chk("R7", {31'd0, load_done}, 32'd1);
    cur_req = "R7";
    send(1, 0, 2'b01, 3'd7, 0, 16'hFFF1, 16'hFFF2, 16'hFFF3);
    chk("R7", {31'd0, load_done}, 32'd1);

    // new load clears done; a second start restarts addresses
    cur_req = "R4";
    send(1, 1, 2'b10, 3'd7, 0, 16'h0BAD, 16'h3001, 16'h3002);
    chk("R4", {31'd0, load_done}, 32'd0);
    send(1, 0, 2'b10, 3'd7, 0, 16'h3011, 16'h3012, 16'h3013);
    send(1, 0, 2'b10, 3'd7, 0, 16'h3021, 16'h3022, 16'h3023);
    send(1, 1, 2'b00, 3'd0, 8'h99, 16'h0BAD, 16'h1001, 16'h1002);
    send(1, 0, 2'b00, 3'd7, 0, 16'h1011, 16'h1012, 16'h1013);
    send(1, 0, 2'b10, 3'd7, 0, 16'h0BAD, 16'h0BAD, 16'h0BAD);

    // reset in the middle of a load
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9", ctrl_regs, 32'd0);
    chk("R9", {31'd0, ram_we}, 32'd0);
    chk("R9", {31'd0, load_done}, 32'd0);
    rst_n = 1'b1;
    cur_req = "R9";
    send(1, 0, 2'b00, 3'd7, 0, 16'h0BAD, 16'h0BAD, 16'h0BAD);
    chk("R9", {31'd0, ram_we}, 32'd0);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule